// File: doc/BRIEF.md
# Pipelined Four-Row Integer Subgraph Unit

This block evaluates a small integer dataflow graph of up to fifteen simple operations as a single issued instruction. Four operand words come in, two result words go out, and a wide configuration word given with every instruction sets each cell's operation and where each cell's two operands come from. The cells sit in four rows of six, four, three and two. A cell may take its operands from the four unit inputs or from the result of any cell in an earlier row, so a chain of dependent operations up to four deep fits in one instruction.

The rows are not alike. The first and third rows can add, subtract, compare and do bitwise logic; the second and fourth rows can only do bitwise logic. A register sits after the second row and another on the outputs, so an instruction issued on one clock edge has its results on the outputs after the second edge, and a new instruction may be issued on every cycle. Shifts, multiplies and memory access are not part of the unit.

Top module: `subgraph_alu`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and `out_data` is all zeros.
- R2: An instruction sampled with `in_valid` high on a rising edge gives `out_valid` high with its results after the next rising edge (two-cycle latency), and instructions issued on consecutive cycles come out on consecutive cycles in issue order.
- R3: Cells are numbered 0 to 14: row one holds 0-5, row two 6-9, row three 10-12, row four 13-14. Cell k is configured by `cfg_in[14k+13:14k]` as opcode in bits 13:10, operand A source in bits 9:5 and operand B source in bits 4:0. Source index 0-3 names unit input 0-3, and index 4+k names the result of cell k. Result 0 source is `cfg_in[213:210]` and result 1 source is `cfg_in[217:214]`, each a cell number.
- R4: In rows one and three, opcode 8 gives A+B and opcode 9 gives A-B, both modulo 2^DATA_W.
- R5: In rows one and three, opcode 10 gives 1 if A equals B, opcode 11 gives 1 if A is less than B as signed numbers, opcode 12 gives 1 if A is less than B as unsigned numbers, and 0 otherwise; the 1 or 0 is zero-extended to the full width.
- R6: In every row, opcodes 0 to 5 give A, A AND B, A OR B, A XOR B, A AND NOT B, and NOT (A OR B), respectively.
- R7: In rows two and four, opcodes 8 to 12 give zero.
- R8: Opcodes 6, 7 and 13 to 15 give zero in every row.
- R9: An operand source index that names a cell in the same row or a later row, or is 19 or above, reads as zero.
- R10: A result source value of 15 gives zero on that result.
- R11: Whenever `out_valid` is low after reset, `out_data` is all zeros.
- R12: Arbitrary configurations that chain through all four rows and across the inner pipeline register give the results defined by R3 to R10 for every instruction of a back-to-back stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue an instruction this cycle |
| in_data | input | 4*DATA_W | Operand inputs, input i in bits [i*DATA_W +: DATA_W] |
| cfg_in | input | 218 | Per-cell opcodes and sources plus the two result selects |
| out_valid | output | 1 | Results of an instruction issued two edges earlier |
| out_data | output | 2*DATA_W | Result 0 in the low word, result 1 in the high word |

## Verification
The timing assertions assume that `in_valid` is low while reset is high, so that an instruction never straddles the end of reset; the bench holds it low until reset has been released. The assertion on the first-row adder and the one on the null result select relate the configuration held two edges earlier to the outputs, which assumes `cfg_in` and `in_data` are sampled only together with `in_valid`; the stimulus changes them only at falling edges. Directed instructions pin each opcode, each row restriction and each out-of-window source, and a long back-to-back random stream drives arbitrary configurations through all four rows against a model built from the requirements.

// File: rtl/sg_pkg.sv
package sg_pkg;

    localparam int NUM_IN     = 4;
    localparam int NUM_OUT    = 2;
    localparam int NUM_ROWS   = 4;
    localparam int NUM_CELLS  = 15;
    localparam int NUM_SRC    = NUM_IN + NUM_CELLS;
    localparam int SRC_W      = 5;
    localparam int OP_W       = 4;
    localparam int CELL_CFG_W = OP_W + 2 * SRC_W;
    localparam int OSEL_W     = 4;
    localparam int CELL_BITS  = NUM_CELLS * CELL_CFG_W;
    localparam int CFG_W      = CELL_BITS + NUM_OUT * OSEL_W;

    typedef enum logic [OP_W-1:0] {
        OP_PASS = 4'd0,
        OP_AND  = 4'd1,
        OP_OR   = 4'd2,
        OP_XOR  = 4'd3,
        OP_ANDN = 4'd4,
        OP_NOR  = 4'd5,
        OP_ADD  = 4'd8,
        OP_SUB  = 4'd9,
        OP_EQ   = 4'd10,
        OP_SLT  = 4'd11,
        OP_SLTU = 4'd12
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [SRC_W-1:0] sel_a;
        logic [SRC_W-1:0] sel_b;
    } cell_cfg_t;

    function automatic int row_cells(input int r);
        case (r)
            0:       return 6;
            1:       return 4;
            2:       return 3;
            default: return 2;
        endcase
    endfunction

    function automatic int row_first(input int r);
        int acc;
        acc = 0;
        for (int i = 0; i < r; i++) acc += row_cells(i);
        return acc;
    endfunction

    function automatic bit row_arith(input int r);
        return (r % 2) == 0;
    endfunction

endpackage

// File: rtl/sg_cell.sv
module sg_cell
    import sg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter bit ARITH  = 1'b1
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] arith_y;
    logic [DATA_W-1:0] logic_y;
    logic              is_arith;

    // arithmetic and compare results
    always_comb begin
        arith_y  = '0;
        is_arith = 1'b1;
        case (op)
            OP_ADD:  arith_y = a + b;
            OP_SUB:  arith_y = a - b;
            OP_EQ:   arith_y = (a == b) ? ONE : '0;
            OP_SLT:  arith_y = ($signed(a) < $signed(b)) ? ONE : '0;
            OP_SLTU: arith_y = (a < b) ? ONE : '0;
            default: is_arith = 1'b0;
        endcase
    end

    // bitwise results, legal in every row
    always_comb begin
        case (op)
            OP_PASS: logic_y = a;
            OP_AND:  logic_y = a & b;
            OP_OR:   logic_y = a | b;
            OP_XOR:  logic_y = a ^ b;
            OP_ANDN: logic_y = a & ~b;
            OP_NOR:  logic_y = ~(a | b);
            default: logic_y = '0;
        endcase
    end

    generate
        if (ARITH) begin : g_full
            assign y = is_arith ? arith_y : logic_y;
        end else begin : g_logic_only
            assign y = is_arith ? '0 : logic_y;
        end
    endgenerate

endmodule

// File: rtl/sg_row.sv
module sg_row
    import sg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NSRC   = NUM_SRC,
    parameter int NCELL  = 1,
    parameter bit ARITH  = 1'b1
) (
    input  logic [NCELL-1:0][CELL_CFG_W-1:0] cfg,
    input  logic [DATA_W-1:0]                srcs [NSRC],
    output logic [DATA_W-1:0]                y    [NCELL]
);

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        cell_cfg_t         cc;
        logic [DATA_W-1:0] opa;
        logic [DATA_W-1:0] opb;

        assign cc = cell_cfg_t'(cfg[c]);

        // operand crossbar; indices past NSRC match nothing and read zero
        always_comb begin
            opa = '0;
            opb = '0;
            for (int j = 0; j < NSRC; j++) begin
                if (cc.sel_a == SRC_W'(j)) opa = srcs[j];
                if (cc.sel_b == SRC_W'(j)) opb = srcs[j];
            end
        end

        sg_cell #(
            .DATA_W (DATA_W),
            .ARITH  (ARITH)
        ) u_cell (
            .op (cc.op),
            .a  (opa),
            .b  (opb),
            .y  (y[c])
        );
    end

endmodule

// File: rtl/subgraph_alu.sv
module subgraph_alu
    import sg_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int PIPE_SPLIT = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [NUM_IN*DATA_W-1:0]  in_data,
    input  logic [CFG_W-1:0]          cfg_in,
    output logic                      out_valid,
    output logic [NUM_OUT*DATA_W-1:0] out_data
);

    localparam int MID_N = NUM_IN + row_first(PIPE_SPLIT);

    logic [NUM_IN-1:0][DATA_W-1:0] in_vec;
    logic [DATA_W-1:0]             pre_src  [NUM_SRC];
    logic [DATA_W-1:0]             post_src [NUM_SRC];
    logic [DATA_W-1:0]             mid_q    [MID_N];
    logic                          mid_valid;
    logic [CFG_W-1:0]              cfg_q;
    logic [NUM_OUT-1:0][DATA_W-1:0] out_nxt;
    logic [NUM_OUT-1:0][DATA_W-1:0] out_q;
    logic                          out_valid_q;
    logic [OSEL_W-1:0]             osel [NUM_OUT];

    assign in_vec = in_data;

    // source slots fed before the inner register
    for (genvar j = 0; j < NUM_IN; j++) begin : g_pre_in
        assign pre_src[j] = in_vec[j];
    end
    for (genvar j = MID_N; j < NUM_SRC; j++) begin : g_pre_zero
        assign pre_src[j] = '0;
    end
    for (genvar j = 0; j < MID_N; j++) begin : g_post_mid
        assign post_src[j] = mid_q[j];
    end

    // four rows, each seeing only the inputs and earlier rows
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        localparam int NC    = row_cells(r);
        localparam int FIRST = row_first(r);
        localparam int LIM   = NUM_IN + FIRST;

        logic [DATA_W-1:0]            rsrc [NUM_SRC];
        logic [DATA_W-1:0]            ry   [NC];
        logic [NC-1:0][CELL_CFG_W-1:0] rcfg;

        for (genvar j = 0; j < NUM_SRC; j++) begin : g_src
            if (j >= LIM) begin : g_zero
                assign rsrc[j] = '0;
            end else if (r < PIPE_SPLIT) begin : g_early
                assign rsrc[j] = pre_src[j];
            end else begin : g_late
                assign rsrc[j] = post_src[j];
            end
        end

        if (r < PIPE_SPLIT) begin : g_cfg_early
            assign rcfg = cfg_in[FIRST*CELL_CFG_W +: NC*CELL_CFG_W];
        end else begin : g_cfg_late
            assign rcfg = cfg_q[FIRST*CELL_CFG_W +: NC*CELL_CFG_W];
        end

        sg_row #(
            .DATA_W (DATA_W),
            .NSRC   (NUM_SRC),
            .NCELL  (NC),
            .ARITH  (row_arith(r))
        ) u_row (
            .cfg  (rcfg),
            .srcs (rsrc),
            .y    (ry)
        );

        for (genvar c = 0; c < NC; c++) begin : g_out
            if (r < PIPE_SPLIT) begin : g_to_pre
                assign pre_src[LIM + c] = ry[c];
            end else begin : g_to_post
                assign post_src[LIM + c] = ry[c];
            end
        end
    end

    // inner pipeline register
    always_ff @(posedge clk) begin
        if (rst) begin
            mid_valid <= 1'b0;
            cfg_q     <= '0;
            for (int j = 0; j < MID_N; j++) mid_q[j] <= '0;
        end else begin
            mid_valid <= in_valid;
            cfg_q     <= cfg_in;
            for (int j = 0; j < MID_N; j++) mid_q[j] <= pre_src[j];
        end
    end

    // result selection from any cell
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_osel
        assign osel[o] = cfg_q[CELL_BITS + o*OSEL_W +: OSEL_W];
    end

    always_comb begin
        out_nxt = '0;
        for (int o = 0; o < NUM_OUT; o++) begin
            for (int k = 0; k < NUM_CELLS; k++) begin
                if (osel[o] == OSEL_W'(k)) out_nxt[o] = post_src[NUM_IN + k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_q <= 1'b0;
            out_q       <= '0;
        end else begin
            out_valid_q <= mid_valid;
            out_q       <= mid_valid ? out_nxt : '0;
        end
    end

    assign out_valid = out_valid_q;
    assign out_data  = out_q;

endmodule

// File: rtl/sg_chk.sv
module sg_chk
    import sg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      in_valid,
    input logic [NUM_IN*DATA_W-1:0]  in_data,
    input logic [CFG_W-1:0]          cfg_in,
    input logic                      out_valid,
    input logic [NUM_OUT*DATA_W-1:0] out_data
);

    localparam logic [CELL_CFG_W-1:0] ADD_IN0_IN1 = {OP_ADD, 5'd0, 5'd1};

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_data == '0)) else $error("reset idle"); // R1

    AST_ISSUE_TO_RESULT: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid, 2) && !$past(rst, 1) && !$past(rst, 2)) |-> out_valid) else $error("latency"); // R2

    AST_RESULT_HAS_ISSUE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2)) else $error("spurious result"); // R2

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> out_data == '0) else $error("idle data"); // R11

    AST_NULL_SELECT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(cfg_in[CELL_BITS +: OSEL_W], 2) == 4'hF)
        |-> out_data[DATA_W-1:0] == '0) else $error("null select"); // R10

    AST_ROW1_ADD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(cfg_in[CELL_CFG_W-1:0], 2) == ADD_IN0_IN1
         && $past(cfg_in[CELL_BITS +: OSEL_W], 2) == 4'h0)
        |-> out_data[DATA_W-1:0] ==
            $past(in_data[0 +: DATA_W] + in_data[DATA_W +: DATA_W], 2)) else $error("row1 add"); // R4

endmodule

bind subgraph_alu sg_chk #(.DATA_W(DATA_W)) u_sg_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .cfg_in    (cfg_in),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/subgraph_alu_bench.sv
module subgraph_alu_bench;
    import sg_pkg::*;

    localparam int DW = 32;
    typedef logic [CFG_W-1:0] cfg_t;
    typedef struct {
        logic [2*DW-1:0] exp;
        string           tag;
    } item_t;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic [NUM_IN*DW-1:0] in_data = '0;
    cfg_t                 cfg_in = '0;
    logic                 out_valid;
    logic [NUM_OUT*DW-1:0] out_data;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    item_t sbq [$];

    always #5 clk = ~clk;

    subgraph_alu #(.DATA_W(DW)) u_subgraph_alu (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .cfg_in    (cfg_in),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic cfg_t put_cell(cfg_t c, int k, logic [3:0] op, logic [4:0] a, logic [4:0] b);
        c[14*k +: 14] = {op, a, b};
        return c;
    endfunction

    function automatic cfg_t put_osel(cfg_t c, logic [3:0] s0, logic [3:0] s1);
        c[210 +: 4] = s0;
        c[214 +: 4] = s1;
        return c;
    endfunction

    // reference model written from R3..R10
    function automatic logic [2*DW-1:0] model(cfg_t c, logic [NUM_IN*DW-1:0] ins);
        logic [DW-1:0] s [19];
        logic [DW-1:0] a, b, y, r0, r1;
        logic [3:0]    op, s0, s1;
        int            sa, sb, lim, row;
        bit            ar;
        for (int i = 0; i < 19; i++) s[i] = '0;
        for (int i = 0; i < 4; i++) s[i] = ins[i*DW +: DW];
        for (int k = 0; k < 15; k++) begin
            row = (k < 6) ? 0 : (k < 10) ? 1 : (k < 13) ? 2 : 3;
            lim = 4 + ((row == 0) ? 0 : (row == 1) ? 6 : (row == 2) ? 10 : 13);
            ar  = (row == 0) || (row == 2);
            op  = c[14*k + 10 +: 4];
            sa  = int'(c[14*k + 5 +: 5]);
            sb  = int'(c[14*k +: 5]);
            a   = (sa < lim) ? s[sa] : '0;
            b   = (sb < lim) ? s[sb] : '0;
            case (op)
                4'd0:  y = a;
                4'd1:  y = a & b;
                4'd2:  y = a | b;
                4'd3:  y = a ^ b;
                4'd4:  y = a & ~b;
                4'd5:  y = ~(a | b);
                4'd8:  y = ar ? a + b : '0;
                4'd9:  y = ar ? a - b : '0;
                4'd10: y = (ar && a == b) ? 1 : 0;
                4'd11: y = (ar && $signed(a) < $signed(b)) ? 1 : 0;
                4'd12: y = (ar && a < b) ? 1 : 0;
                default: y = '0;
            endcase
            s[4 + k] = y;
        end
        s0 = c[210 +: 4];
        s1 = c[214 +: 4];
        r0 = (s0 < 15) ? s[4 + int'(s0)] : '0;
        r1 = (s1 < 15) ? s[4 + int'(s1)] : '0;
        return {r1, r0};
    endfunction

    task automatic issue(cfg_t c, logic [DW-1:0] i0, i1, i2, i3, string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        cfg_in   = c;
        in_data  = {i3, i2, i1, i0};
        it.exp   = model(c, {i3, i2, i1, i0});
        it.tag   = tag;
        sbq.push_back(it);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            cfg_in   = '0;
            in_data  = '0;
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            if (out_valid) begin
                checks++;
                if (sbq.size() == 0) begin
                    errors++;
                    $display("FAIL R2 unexpected result act=%h exp=none", out_data);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    if (out_data !== it.exp) begin
                        errors++;
                        $display("FAIL %s act=%h exp=%h", it.tag, out_data, it.exp);
                    end
                end
            end else begin
                checks++;
                if (out_data !== '0) begin
                    errors++;
                    $display("FAIL R11 idle data act=%h exp=0", out_data);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog act=timeout exp=completion");
            summary();
            $finish;
        end
    end

    initial begin
        cfg_t c;
        repeat (4) @(negedge clk);
        #1;
        checks++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            errors++;
            $display("FAIL R1 reset act=%b/%h exp=0/0", out_valid, out_data);
        end
        rst = 1'b0;
        #1;
        idle(2);

        // R4: add with wrap and subtract in row one
        c = put_cell('0, 0, 4'd8, 5'd0, 5'd1);
        c = put_cell(c, 1, 4'd9, 5'd2, 5'd3);
        c = put_osel(c, 4'd0, 4'd1);
        issue(c, 32'hFFFF_FFFF, 32'd2, 32'd5, 32'd7, "R4 add/sub");
        idle(3);

        // R5: signed vs unsigned less-than, equality
        c = put_cell('0, 0, 4'd11, 5'd0, 5'd1);
        c = put_cell(c, 1, 4'd12, 5'd0, 5'd1);
        c = put_osel(c, 4'd0, 4'd1);
        issue(c, 32'hFFFF_FFFF, 32'd1, 32'd0, 32'd0, "R5 slt/sltu");
        c = put_cell('0, 4, 4'd10, 5'd2, 5'd3);
        c = put_cell(c, 5, 4'd10, 5'd0, 5'd3);
        c = put_osel(c, 4'd4, 4'd5);
        issue(c, 32'd9, 32'd0, 32'h1234_5678, 32'h1234_5678, "R5 eq");
        idle(3);

        // R6: logic ops across all four rows
        c = put_cell('0, 0, 4'd5, 5'd0, 5'd2);
        c = put_cell(c, 6, 4'd3, 5'd4, 5'd1);
        c = put_cell(c, 10, 4'd0, 5'd10, 5'd0);
        c = put_cell(c, 13, 4'd4, 5'd14, 5'd3);
        c = put_osel(c, 4'd13, 4'd6);
        issue(c, 32'h0F0F_00FF, 32'hAAAA_5555, 32'h00F0_1200, 32'h0000_FFFF, "R6 logic chain");
        c = put_cell('0, 2, 4'd1, 5'd0, 5'd1);
        c = put_cell(c, 3, 4'd2, 5'd0, 5'd1);
        c = put_osel(c, 4'd2, 4'd3);
        issue(c, 32'hF0F0_F0F0, 32'h3C3C_3C3C, 32'd0, 32'd0, "R6 and/or");
        idle(3);

        // R7: arithmetic codes in logic-only rows
        c = put_cell('0, 6, 4'd8, 5'd0, 5'd1);
        c = put_cell(c, 13, 4'd11, 5'd0, 5'd1);
        c = put_osel(c, 4'd6, 4'd13);
        issue(c, 32'd3, 32'd4, 32'd0, 32'd0, "R7 even-row arith");
        // R8: undefined opcodes
        c = put_cell('0, 2, 4'd14, 5'd0, 5'd1);
        c = put_cell(c, 3, 4'd6, 5'd0, 5'd1);
        c = put_osel(c, 4'd2, 4'd3);
        issue(c, 32'd3, 32'd4, 32'd0, 32'd0, "R8 undefined op");
        idle(3);

        // R9: sources outside the window read zero
        c = put_cell('0, 0, 4'd2, 5'd4, 5'd0);
        c = put_cell(c, 10, 4'd2, 5'd14, 5'd1);
        c = put_osel(c, 4'd0, 4'd10);
        issue(c, 32'h1111_0000, 32'h0000_2222, 32'd0, 32'd0, "R9 same-row source");
        c = put_cell('0, 6, 4'd2, 5'd12, 5'd25);
        c = put_cell(c, 7, 4'd2, 5'd31, 5'd2);
        c = put_osel(c, 4'd6, 4'd7);
        issue(c, 32'd1, 32'd2, 32'h0000_0BEE, 32'd4, "R9 later/out-of-range source");
        // R10: null result select
        c = put_cell('0, 0, 4'd8, 5'd0, 5'd1);
        c = put_osel(c, 4'hF, 4'hF);
        issue(c, 32'd10, 32'd20, 32'd0, 32'd0, "R10 null select");
        idle(3);

        // R3: last cells of rows three and four via their field slots
        c = put_cell('0, 12, 4'd8, 5'd0, 5'd3);
        c = put_cell(c, 14, 4'd0, 5'd16, 5'd0);
        c = put_osel(c, 4'd12, 4'd14);
        issue(c, 32'd100, 32'd0, 32'd0, 32'd23, "R3 field layout");
        // R2: back-to-back issue in order
        c = put_cell('0, 0, 4'd8, 5'd0, 5'd1);
        c = put_osel(c, 4'd0, 4'd0);
        for (int i = 0; i < 4; i++) issue(c, 32'(i * 7), 32'd1000, 32'd0, 32'd0, "R2 back-to-back");
        idle(3);

        // R12: random configurations through all rows
        for (int n = 0; n < 300; n++) begin
            for (int w = 0; w < 7; w++) c[w*32 +: 32] = $urandom;
            if (n % 3 != 2) begin
                for (int k = 0; k < 15; k++) c[14*k + 13] = 1'b0;
                for (int k = 0; k < 15; k++) c[14*k + 10 +: 4] = 4'($urandom_range(0, 12));
            end
            issue(c, $urandom, $urandom, $urandom, $urandom, "R12 random chain");
            if (n % 17 == 16) idle(1);
        end
        idle(6);

        if (sbq.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R2 missing results act=%0d exp=0", sbq.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule